// File: doc/BRIEF.md
# Low-Frequency Counter Clock-Domain Bridge

This block connects a fast bus clock domain to a slow counter domain that runs at about 32 kHz. Single-cycle task strobes from the bus side are carried over to the slow side. There they appear as one-slow-cycle pulses, but only after the slow clock has shown a falling edge and then a rising edge. Event pulses from the slow side, such as tick, overflow and the compare matches, are synchronized back to the fast side. There they set sticky flags, as long as the event is routed and the counter is in its running state.

Register writes control two enable sets. Routing enables decide which events reach the flags. Interrupt enables decide which flags drive the interrupt line. Both sets use write-one-to-set and write-one-to-clear aliases. A copy of the slow counter value is kept in the fast domain and refreshed just after each slow rising edge, so a read never sees a value that is changing. The counter and compare logic sit outside this block.

Top module: `rtc_cdc_bridge`

## Requirements
- R1: A strobe on `task_i[k]` (0 start, 1 stop, 2 clear, 3 overflow-test preset) gives exactly one high period of `lf_task_o[k]`, one `lf_clk_i` cycle long. It starts at the first `lf_clk_i` rising edge that comes after a falling edge seen after the strobe, and no other task line moves.
- R2: A second strobe of the same task, issued while the first is still in transit, is held and delivered later as a second pulse. Other tasks are not affected.
- R3: An event pulse on `lf_evt_i[i]` (0 tick, 1 overflow, 2+j compare j) sets `evt_flag_o[i]` at the third `clk_i` rising edge after the input goes high. This happens only if the event is routed and the block is running. The flag then stays set.
- R4: An event whose routing enable is 0 never sets its flag.
- R5: A start strobe sets the running state and a stop strobe clears it. An event detected before any start, in the same cycle as a stop strobe, or after a stop strobe sets no flag.
- R6: A write with `reg_sel_i` = 0 loads the routing enables. Codes 1 and 2 set or clear the routing bits written as 1. Codes 3 and 4 set or clear the interrupt-enable bits written as 1. The bit layout is tick at bit 0, overflow at bit 1 and compare j at bit 16+j. All other bits are ignored and read as 0 on `evt_en_o` and `int_en_o`, and a write shows on these outputs after one clock.
- R7: A write with `reg_sel_i` = 5 clears every flag whose layout bit is written 0 and leaves every flag written 1 unchanged. An event detected in the same cycle as this write wins, so its flag ends set.
- R8: `irq_o` is high in exactly the cycles in which some flag is set and its interrupt enable is 1.
- R9: Within three `clk_i` rising edges after each `lf_clk_i` rising edge, `cnt_snap_o` takes the value of `lf_cnt_i`. It holds that value until the next update.
- R10: While reset is asserted, all enables, flags, `irq_o`, `cnt_snap_o` and `lf_task_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| lf_clk_i | input | 1 | Slow counter clock |
| task_i | input | 4 | Task strobes, fast domain |
| lf_task_o | output | 4 | Task pulses, slow domain |
| lf_evt_i | input | NUM_CMP+2 | Event pulses from the slow domain |
| lf_cnt_i | input | CNT_W | Slow-domain counter value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register write target code |
| reg_wdata_i | input | 32 | Register write data |
| evt_en_o | output | 32 | Routing enables in register layout |
| int_en_o | output | 32 | Interrupt enables in register layout |
| evt_flag_o | output | NUM_CMP+2 | Sticky event flags |
| irq_o | output | 1 | Interrupt request |
| cnt_snap_o | output | CNT_W | Stable counter copy |

## Verification
Two pairs of functions can act in the same clock cycle. The first pair is an event detection and a flag-clear write. The second pair is an event detection and a stop strobe. The bench drives the event input at a known fast-clock edge and counts the synchronizer stages, so that the clear write or the stop strobe lands on exactly the edge where the flag would be set. It then judges the result at the port: with the clear write, the new flag must survive while older flags are cleared; with the stop strobe, no flag may appear.

// File: rtl/rtc_bridge_pkg.sv
package rtc_bridge_pkg;
  localparam int NUM_TASKS  = 4;
  localparam int TASK_START = 0;
  localparam int TASK_STOP  = 1;
  localparam int CMP_BASE   = 16;

  typedef enum logic [2:0] {
    REG_EVT_WR  = 3'd0,
    REG_EVT_SET = 3'd1,
    REG_EVT_CLR = 3'd2,
    REG_INT_SET = 3'd3,
    REG_INT_CLR = 3'd4,
    REG_FLAG_WR = 3'd5
  } reg_sel_e;

  // compact event index -> register bit position
  function automatic int evt_bit(input int idx);
    return (idx < 2) ? idx : idx - 2 + CMP_BASE;
  endfunction
endpackage

// File: rtl/rtc_task_link.sv
module rtc_task_link (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lf_clk_i,
  input  logic strobe_i,
  output logic pulse_o
);
  logic tgl_q, pend_q, ack_s1, ack_s2;
  logic ls1, ls2, ls3;
  logic busy, fire;

  assign busy = tgl_q ^ ack_s2;
  assign fire = !busy && (strobe_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      pend_q <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      tgl_q  <= tgl_q ^ fire;
      pend_q <= busy ? (pend_q | strobe_i) : (pend_q & strobe_i);
      ack_s1 <= ls3;
      ack_s2 <= ack_s1;
    end
  end

  // first capture on a falling edge, then rising edges
  always_ff @(negedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) ls1 <= 1'b0;
    else         ls1 <= tgl_q;
  end

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls2 <= 1'b0;
      ls3 <= 1'b0;
    end else begin
      ls2 <= ls1;
      ls3 <= ls2;
    end
  end

  assign pulse_o = ls2 ^ ls3;

  p_pulse_single_r1: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_tgl_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_q != $past(tgl_q)) |-> ($past(tgl_q) == $past(ack_s2)));
endmodule

// File: rtl/rtc_evt_sync.sv
module rtc_evt_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lf_evt_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] s1, s2, s3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= lf_evt_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;
endmodule

// File: rtl/rtc_cnt_shadow.sv
module rtc_cnt_shadow #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lf_clk_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] snap_o
);
  logic c1, c2, c3, lf_rise;

  assign lf_rise = c2 & ~c3;

  // copy only once the slow edge is two flops old: counter has settled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1     <= 1'b0;
      c2     <= 1'b0;
      c3     <= 1'b0;
      snap_o <= '0;
    end else begin
      c1 <= lf_clk_i;
      c2 <= c1;
      c3 <= c2;
      if (lf_rise) snap_o <= cnt_i;
    end
  end

  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lf_rise |=> $stable(snap_o));
endmodule

// File: rtl/rtc_cdc_bridge.sv
module rtc_cdc_bridge
  import rtc_bridge_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int NUM_CMP = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lf_clk_i,
  input  logic [NUM_TASKS-1:0] task_i,
  output logic [NUM_TASKS-1:0] lf_task_o,
  input  logic [NUM_CMP+1:0]   lf_evt_i,
  input  logic [CNT_W-1:0]     lf_cnt_i,
  input  logic                 reg_wr_i,
  input  logic [2:0]           reg_sel_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          evt_en_o,
  output logic [31:0]          int_en_o,
  output logic [NUM_CMP+1:0]   evt_flag_o,
  output logic                 irq_o,
  output logic [CNT_W-1:0]     cnt_snap_o
);
  localparam int NUM_EVT = NUM_CMP + 2;

  logic [NUM_EVT-1:0] evt_en_q, int_en_q, evt_flag_q, evt_flag_d;
  logic [NUM_EVT-1:0] wbits, evt_rise, evt_hit;
  logic               run_q;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  for (genvar k = 0; k < NUM_TASKS; k++) begin : g_task
    rtc_task_link u_link (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lf_clk_i(lf_clk_i),
      .strobe_i(task_i[k]),
      .pulse_o (lf_task_o[k])
    );
  end

  rtc_evt_sync #(.WIDTH(NUM_EVT)) u_evt_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lf_evt_i(lf_evt_i),
    .rise_o  (evt_rise)
  );

  rtc_cnt_shadow #(.CNT_W(CNT_W)) u_cnt_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lf_clk_i(lf_clk_i),
    .cnt_i   (lf_cnt_i),
    .snap_o  (cnt_snap_o)
  );

  always_comb begin
    evt_en_o = '0;
    int_en_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      wbits[i]              = reg_wdata_i[evt_bit(i)];
      evt_en_o[evt_bit(i)]  = evt_en_q[i];
      int_en_o[evt_bit(i)]  = int_en_q[i];
    end
  end

  // stop gates events in this cycle already
  assign evt_hit = evt_rise & evt_en_q & {NUM_EVT{run_q & ~task_i[TASK_STOP]}};

  always_comb begin
    evt_flag_d = evt_flag_q;
    if (reg_wr_i && reg_sel_i == REG_FLAG_WR) evt_flag_d = evt_flag_d & wbits;
    evt_flag_d = evt_flag_d | evt_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_en_q   <= '0;
      int_en_q   <= '0;
      evt_flag_q <= '0;
      run_q      <= 1'b0;
    end else begin
      evt_flag_q <= evt_flag_d;
      if (task_i[TASK_STOP])       run_q <= 1'b0;
      else if (task_i[TASK_START]) run_q <= 1'b1;
      if (reg_wr_i) begin
        case (reg_sel_i)
          REG_EVT_WR:  evt_en_q <= wbits;
          REG_EVT_SET: evt_en_q <= evt_en_q | wbits;
          REG_EVT_CLR: evt_en_q <= evt_en_q & ~wbits;
          REG_INT_SET: int_en_q <= int_en_q | wbits;
          REG_INT_CLR: int_en_q <= int_en_q & ~wbits;
          default: ;
        endcase
      end
    end
  end

  assign evt_flag_o = evt_flag_q;
  assign irq_o      = |(evt_flag_q & int_en_q);

  p_evt_routed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flag_q & ~$past(evt_flag_q) & ~$past(evt_en_q)) == '0);

  p_run_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_flag_q & ~$past(evt_flag_q))) |-> ($past(run_q) && !$past(task_i[TASK_STOP])));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~evt_flag_q & $past(evt_flag_q))) |-> $past(reg_wr_i && reg_sel_i == REG_FLAG_WR));
endmodule

// File: tb/rtc_cdc_bridge_tb.sv
`timescale 1ns/1ps
module rtc_cdc_bridge_tb_top;
  logic        clk = 1'b0;
  logic        lf_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  task_s = '0;
  logic [3:0]  lf_task;
  logic [5:0]  lf_evt = '0;
  logic [23:0] lf_cnt;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] evt_en, int_en;
  logic [5:0]  flags;
  logic        irq;
  logic [23:0] snap;
  logic        jump_en = 1'b0;
  int          n_chk = 0, n_bad = 0;
  int          pcnt [4];
  bit          done = 1'b0;

  rtc_cdc_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lf_clk_i(lf_clk),
    .task_i(task_s), .lf_task_o(lf_task), .lf_evt_i(lf_evt), .lf_cnt_i(lf_cnt),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .evt_en_o(evt_en), .int_en_o(int_en), .evt_flag_o(flags), .irq_o(irq),
    .cnt_snap_o(snap)
  );

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #50 lf_clk = ~lf_clk;
  end

  // slow-domain counter model
  always @(posedge lf_clk or negedge rst_n)
    if (!rst_n)       lf_cnt <= '0;
    else if (jump_en) lf_cnt <= 24'hFFFFF0;
    else              lf_cnt <= lf_cnt + 24'd1;

  always @(negedge lf_clk or negedge rst_n)
    if (!rst_n) for (int k = 0; k < 4; k++) pcnt[k] <= 0;
    else for (int k = 0; k < 4; k++) if (lf_task[k]) pcnt[k] <= pcnt[k] + 1;

  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] exp_evt;
    logic [31:0] exp_int;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 32'h000F0003, 32'h000F0003, 32'h00000000},
    '{3'd2, 32'h00050001, 32'h000A0002, 32'h00000000},
    '{3'd1, 32'hFFF00001, 32'h000A0003, 32'h00000000},
    '{3'd3, 32'h00030002, 32'h000A0003, 32'h00030002},
    '{3'd4, 32'h00010000, 32'h000A0003, 32'h00020002},
    '{3'd0, 32'h00000000, 32'h00000000, 32'h00020002},
    '{3'd0, 32'hFFFFFFFF, 32'h000F0003, 32'h00020002},
    '{3'd3, 32'h000F0003, 32'h000F0003, 32'h000F0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic evt_pulse(input int i);
    @(negedge clk);
    lf_evt[i] = 1'b1;
    repeat (6) @(negedge clk);
    lf_evt[i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    int c2, c3;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 evt_en", evt_en, 32'h0);
    chk("R10 int_en", int_en, 32'h0);
    chk("R10 flags", {26'd0, flags}, 32'h0);
    chk("R10 irq", {31'd0, irq}, 32'h0);
    chk("R10 snap", {8'd0, snap}, 32'h0);
    chk("R10 task", {28'd0, lf_task}, 32'h0);
    rst_n = 1'b1;

    // R6 register table
    for (int v = 0; v < 8; v++) begin
      wr_reg(VECS[v].sel, VECS[v].data);
      chk("R6 evt_en", evt_en, VECS[v].exp_evt);
      chk("R6 int_en", int_en, VECS[v].exp_int);
    end

    // R5 events before start are dropped
    evt_pulse(0);
    chk("R5 pre-start", {26'd0, flags}, 32'h0);

    // R1 start task timing
    @(negedge lf_clk);
    @(negedge clk); task_s[0] = 1'b1;
    @(negedge clk); task_s[0] = 1'b0;
    @(posedge lf_clk); #2;
    chk("R1 no pulse before fall", {28'd0, lf_task}, 32'h0);
    @(posedge lf_clk); #2;
    chk("R1 pulse", {28'd0, lf_task}, 32'h1);
    @(negedge lf_clk); #2;
    chk("R1 pulse held", {28'd0, lf_task}, 32'h1);
    @(posedge lf_clk); #2;
    chk("R1 pulse ends", {28'd0, lf_task}, 32'h0);

    // R3 latency of event flag
    @(negedge clk); lf_evt[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 not yet", {26'd0, flags}, 32'h0);
    @(negedge clk);
    chk("R3 set", {26'd0, flags}, 32'h4);
    chk("R8 irq on", {31'd0, irq}, 32'h1);
    repeat (5) @(negedge clk); lf_evt[2] = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 sticky", {26'd0, flags}, 32'h4);

    // R8 interrupt masking
    wr_reg(3'd4, 32'h00010000);
    chk("R8 masked", {31'd0, irq}, 32'h0);
    wr_reg(3'd3, 32'h00010000);
    chk("R8 unmasked", {31'd0, irq}, 32'h1);

    // R7 flag write
    wr_reg(3'd5, 32'hFFFFFFFF);
    chk("R7 write ones keeps", {26'd0, flags}, 32'h4);
    wr_reg(3'd5, 32'h000E0003);
    chk("R7 write zero clears", {26'd0, flags}, 32'h0);
    chk("R8 irq off", {31'd0, irq}, 32'h0);

    // R4 unrouted event
    wr_reg(3'd2, 32'h00020000);
    evt_pulse(3);
    chk("R4 unrouted", {26'd0, flags}, 32'h0);
    evt_pulse(1);
    chk("R4 routed", {26'd0, flags}, 32'h2);

    // R7 collision: event vs clear write
    evt_pulse(5);
    chk("R3 cmp3", {26'd0, flags}, 32'h22);
    @(negedge clk); lf_evt[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h0;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 event wins", {26'd0, flags}, 32'h1);
    repeat (4) @(negedge clk); lf_evt[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R2 back-to-back task strobes
    c2 = pcnt[2]; c3 = pcnt[3];
    @(negedge clk); task_s[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); task_s[2] = 1'b0;
    repeat (12) @(posedge lf_clk);
    #5;
    chk("R2 two pulses", pcnt[2] - c2, 32'd2);
    chk("R2 other task idle", pcnt[3] - c3, 32'd0);

    // R5 stop in same cycle as detection
    @(negedge clk); lf_evt[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); task_s[1] = 1'b1;
    @(negedge clk); task_s[1] = 1'b0;
    chk("R5 stop same cycle", {26'd0, flags}, 32'h1);
    repeat (4) @(negedge clk); lf_evt[4] = 1'b0;
    repeat (4) @(negedge clk);
    evt_pulse(4);
    chk("R5 after stop", {26'd0, flags}, 32'h1);

    // R9 counter snapshot
    for (int n = 0; n < 3; n++) begin
      @(posedge lf_clk); #20;
      chk("R9 after rise", {8'd0, snap}, {8'd0, lf_cnt});
      @(negedge lf_clk); #20;
      chk("R9 held", {8'd0, snap}, {8'd0, lf_cnt});
    end
    @(negedge lf_clk); jump_en = 1'b1;
    @(posedge lf_clk); #1 jump_en = 1'b0;
    #19;
    chk("R9 jump", {8'd0, snap}, 32'h00FFFFF0);
    @(posedge lf_clk); #20;
    chk("R9 next", {8'd0, snap}, 32'h00FFFFF1);

    done = 1'b1;
    finish_run();
  end
endmodule